// File: doc/BRIEF.md
# Configuration Space Access Router

This block sits behind a memory-mapped slave port and serves configuration reads and writes that fall inside a fixed window above a programmable base address. It subtracts the base from the incoming address and splits the resulting offset into a device number, a function number and a register offset. A 256-bit presence mask then says whether that device and function slot holds anything.

Accesses to a populated slot are passed on to a downstream request port, and read data from that port is returned to the requester. A read to an empty slot completes normally and returns all ones at the access width. A write to an empty slot, an access of an illegal size, or an address outside the window completes with an error flag and is not passed on.

Only one transaction is in flight at a time. The response arrives after a latency that is sampled from an input at acceptance time.

Top module: `cfg_access_router`

## Requirements
- R1: After synchronous active-high reset, `req_ready` is 1 and `rsp_valid`, `rsp_error` and `dn_valid` are 0.
- R2: Once a request is accepted (`req_valid` and `req_ready` both high at a clock edge), `req_ready` stays low up to and including the response cycle. It is high again in the cycle that follows.
- R3: For an accepted request with sampled latency L (`cfg_latency`), `rsp_valid` is high for exactly one cycle, L+1 cycles after the acceptance cycle.
- R4: An address is inside the window only when addr >= `base_addr` and addr − `base_addr` < 0xFFFFFF. Any other address completes with `rsp_error`=1 and is not forwarded.
- R5: With offset = addr − `base_addr`, the device is offset[15:11], the function is offset[10:8] and the register is offset[7:0]. The slot is populated when bit {device,function} (device×8+function) of `present_mask` is 1.
- R6: `req_size` is a byte count in which only 1, 2 and 4 are legal. Any other code completes with `rsp_error`=1 and is not forwarded.
- R7: A legal-size, in-window read to an unpopulated slot returns 0xFF, 0xFFFF or 0xFFFFFFFF (zero-extended to 32 bits) for sizes 1, 2 and 4. It returns `rsp_error`=0 and raises no `dn_valid`.
- R8: A legal-size, in-window write to an unpopulated slot completes with `rsp_error`=1 and raises no `dn_valid`.
- R9: A forwarded access raises `dn_valid` for one cycle, in the cycle after acceptance. `dn_dev`, `dn_func`, `dn_reg`, `dn_size`, `dn_write` and `dn_wdata` carry the request fields and hold until the next acceptance.
- R10: A read to a populated slot returns `dn_rdata` as seen in the response cycle, masked to the access width with the upper bytes zero, and `rsp_error`=0.
- R11: A write to a populated slot completes with `rsp_error`=0, and every response that carries an error or belongs to a write has `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | 32 | Window base address |
| cfg_latency | input | 8 | Response latency, sampled at acceptance |
| present_mask | input | 256 | Slot presence, bit index device×8+function |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Request address |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Read data |
| rsp_error | output | 1 | Response carries an error |
| dn_valid | output | 1 | Downstream request pulse |
| dn_write | output | 1 | Downstream write flag |
| dn_dev | output | 5 | Downstream device number |
| dn_func | output | 3 | Downstream function number |
| dn_reg | output | 8 | Downstream register offset |
| dn_size | output | 3 | Downstream access size |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid in response cycle |

## Verification
The embedded properties assume that `present_mask` and `base_addr` do not change while a request is being accepted. They also assume that `dn_rdata` depends only on the held downstream fields. The stimulus meets these assumptions in three ways. It programs the mask and base only while the block is idle. It holds `req_valid` for a single cycle per transaction. Its downstream model computes `dn_rdata` combinationally from `dn_dev`, `dn_func` and `dn_reg`.

The random addresses are mostly placed inside the window, with deliberate misses below the base and at the top boundary. Sizes mix the three legal codes with illegal ones.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int DEV_W    = 5;
    localparam int FUNC_W   = 3;
    localparam int REG_W    = 8;
    localparam int SIZE_W   = 3;
    localparam int SLOT_W   = DEV_W + FUNC_W;
    localparam int N_SLOTS  = 1 << SLOT_W;
    localparam int OFF_W    = 24;
    localparam logic [ADDR_W-1:0] WINDOW_SPAN = 32'h00FF_FFFF;

    typedef enum logic [1:0] {
        ACC_FWD  = 2'd0,
        ACC_ONES = 2'd1,
        ACC_ERR  = 2'd2,
        ACC_WACK = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic              in_window;
        logic              size_ok;
        logic [DEV_W-1:0]  dev;
        logic [FUNC_W-1:0] func;
        logic [REG_W-1:0]  regno;
    } cfg_fields_t;

    function automatic logic legal_size(input logic [SIZE_W-1:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input logic [SIZE_W-1:0] sz);
        case (sz)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            3'd4:    return 32'hFFFF_FFFF;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/cfg_window_decode.sv
module cfg_window_decode
    import cfg_route_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [SIZE_W-1:0] size,
    output cfg_fields_t       fields
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset           = addr - base;
        fields.in_window = (addr >= base) && (offset < WINDOW_SPAN);
        fields.size_ok   = legal_size(size);
        fields.dev       = offset[15:11];
        fields.func      = offset[10:8];
        fields.regno     = offset[REG_W-1:0];
    end
endmodule

// File: rtl/cfg_slot_lookup.sv
module cfg_slot_lookup
    import cfg_route_pkg::*;
(
    input  logic [N_SLOTS-1:0] mask,
    input  logic [DEV_W-1:0]   dev,
    input  logic [FUNC_W-1:0]  func,
    output logic               present
);
    logic [SLOT_W-1:0] slot;
    always_comb begin
        slot    = {dev, func};
        present = mask[slot];
    end
endmodule

// File: rtl/cfg_latency_timer.sv
module cfg_latency_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] delay,
    output logic             busy,
    output logic             fire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= delay;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign fire = busy && (cnt == '0);

    assert_countdown_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0 && !start) |=> (busy && cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
    import cfg_route_pkg::*;
#(
    parameter int LAT_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [LAT_W-1:0]    cfg_latency,
    input  logic [N_SLOTS-1:0]  present_mask,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [SIZE_W-1:0]   req_size,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_error,
    output logic                dn_valid,
    output logic                dn_write,
    output logic [DEV_W-1:0]    dn_dev,
    output logic [FUNC_W-1:0]   dn_func,
    output logic [REG_W-1:0]    dn_reg,
    output logic [SIZE_W-1:0]   dn_size,
    output logic [DATA_W-1:0]   dn_wdata,
    input  logic [DATA_W-1:0]   dn_rdata
);
    cfg_fields_t       fld;
    logic              present;
    logic              busy;
    logic              fire;
    logic              accept;
    acc_kind_e         kind_d;
    acc_kind_e         kind_q;
    logic [DATA_W-1:0] mask_q;

    cfg_window_decode u_decode (
        .addr   (req_addr),
        .base   (base_addr),
        .size   (req_size),
        .fields (fld)
    );

    cfg_slot_lookup u_lookup (
        .mask    (present_mask),
        .dev     (fld.dev),
        .func    (fld.func),
        .present (present)
    );

    cfg_latency_timer #(.CNT_W(LAT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .delay (cfg_latency),
        .busy  (busy),
        .fire  (fire)
    );

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;

    always_comb begin
        if (!fld.in_window || !fld.size_ok) kind_d = ACC_ERR;
        else if (!present)                  kind_d = req_write ? ACC_ERR : ACC_ONES;
        else                                kind_d = req_write ? ACC_WACK : ACC_FWD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q   <= ACC_ERR;
            mask_q   <= '0;
            dn_valid <= 1'b0;
            dn_write <= 1'b0;
            dn_dev   <= '0;
            dn_func  <= '0;
            dn_reg   <= '0;
            dn_size  <= '0;
            dn_wdata <= '0;
        end else begin
            dn_valid <= accept && (kind_d == ACC_FWD || kind_d == ACC_WACK);
            if (accept) begin
                kind_q   <= kind_d;
                mask_q   <= width_mask(req_size);
                dn_write <= req_write;
                dn_dev   <= fld.dev;
                dn_func  <= fld.func;
                dn_reg   <= fld.regno;
                dn_size  <= req_size;
                dn_wdata <= req_wdata;
            end
        end
    end

    always_comb begin
        rsp_valid = fire;
        rsp_error = fire && (kind_q == ACC_ERR);
        rsp_rdata = '0;
        if (fire) begin
            case (kind_q)
                ACC_FWD:  rsp_rdata = dn_rdata & mask_q;
                ACC_ONES: rsp_rdata = mask_q;
                default:  rsp_rdata = '0;
            endcase
        end
    end

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

    assert_no_fwd_on_error_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && (!fld.in_window || !fld.size_ok || !present)) |=> !dn_valid);

    assert_error_zero_data_R11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_error) |-> (rsp_rdata == '0));

    assert_dn_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        dn_valid |=> !dn_valid);
endmodule

// File: tb/cfg_access_router_bench.sv
module cfg_access_router_bench;
    import cfg_route_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic [31:0]        base_addr;
    logic [7:0]         cfg_latency;
    logic [255:0]       present_mask;
    logic               req_valid, req_ready, req_write;
    logic [31:0]        req_addr, req_wdata;
    logic [2:0]         req_size;
    logic               rsp_valid, rsp_error;
    logic [31:0]        rsp_rdata;
    logic               dn_valid, dn_write;
    logic [4:0]         dn_dev;
    logic [2:0]         dn_func;
    logic [7:0]         dn_reg;
    logic [2:0]         dn_size;
    logic [31:0]        dn_wdata, dn_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] model_rdata(input logic [4:0] d, input logic [2:0] f,
                                                input logic [7:0] r);
        return {r ^ 8'h3C, f, d, 8'h5A, r};
    endfunction

    assign dn_rdata = model_rdata(dn_dev, dn_func, dn_reg);

    cfg_access_router u_cfg_access_router (
        .clk(clk), .rst(rst), .base_addr(base_addr), .cfg_latency(cfg_latency),
        .present_mask(present_mask), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_error(rsp_error), .dn_valid(dn_valid), .dn_write(dn_write),
        .dn_dev(dn_dev), .dn_func(dn_func), .dn_reg(dn_reg), .dn_size(dn_size),
        .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] szmask(input logic [2:0] s);
        case (s)
            3'd1: return 32'hFF;
            3'd2: return 32'hFFFF;
            3'd4: return 32'hFFFFFFFF;
            default: return 32'h0;
        endcase
    endfunction

    task automatic access(input bit wr, input logic [31:0] addr, input logic [2:0] sz,
                          input logic [31:0] wd, input logic [7:0] lat);
        logic [31:0] off;
        bit          inwin, szok, pres, fwd, experr;
        logic [4:0]  ed;
        logic [2:0]  ef;
        logic [7:0]  er;
        logic [31:0] erd;
        off   = addr - base_addr;
        inwin = (addr >= base_addr) && (off < 32'h00FFFFFF);
        szok  = (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
        ed    = off[15:11];
        ef    = off[10:8];
        er    = off[7:0];
        pres  = present_mask[{ed, ef}];
        fwd   = inwin && szok && pres;
        experr = !inwin || !szok || (wr && !pres);
        if (experr || wr)  erd = 32'h0;
        else if (!pres)    erd = szmask(sz);
        else               erd = model_rdata(ed, ef, er) & szmask(sz);

        @(negedge clk);
        check(req_ready == 1'b1, "R2 ready before request", {63'd0, req_ready}, 64'd1);
        req_valid   = 1'b1;
        req_write   = wr;
        req_addr    = addr;
        req_size    = sz;
        req_wdata   = wd;
        cfg_latency = lat;
        @(negedge clk);
        req_valid   = 1'b0;
        cfg_latency = 8'hFF;
        check(dn_valid == fwd, "R9 dn_valid after accept", {63'd0, dn_valid}, {63'd0, fwd});
        if (fwd) begin
            check({dn_dev, dn_func, dn_reg} == {ed, ef, er}, "R5 decoded fields",
                  {48'd0, dn_dev, dn_func, dn_reg}, {48'd0, ed, ef, er});
            check(dn_write == wr && dn_size == sz && dn_wdata == wd, "R9 forwarded data",
                  {28'd0, dn_write, dn_size, dn_wdata}, {28'd0, wr, sz, wd});
        end
        for (int k = 0; k <= int'(lat); k++) begin
            if (k > 0) begin
                @(negedge clk);
                check(dn_valid == 1'b0, "R9 dn_valid single pulse", {63'd0, dn_valid}, 64'd0);
            end
            check(req_ready == 1'b0, "R2 ready low while pending", {63'd0, req_ready}, 64'd0);
            check(rsp_valid == (k == int'(lat)), "R3 response timing",
                  {63'd0, rsp_valid}, {63'd0, (k == int'(lat))});
        end
        if (experr && !inwin)
            check(rsp_error == 1'b1, "R4 window miss error", {63'd0, rsp_error}, 64'd1);
        else if (experr && !szok)
            check(rsp_error == 1'b1, "R6 illegal size error", {63'd0, rsp_error}, 64'd1);
        else if (experr)
            check(rsp_error == 1'b1, "R8 empty slot write error", {63'd0, rsp_error}, 64'd1);
        else if (!wr && !pres)
            check(rsp_error == 1'b0 && rsp_rdata == erd, "R7 all-ones read",
                  {31'd0, rsp_error, rsp_rdata}, {32'd0, erd});
        else if (!wr)
            check(rsp_error == 1'b0 && rsp_rdata == erd, "R10 forwarded read data",
                  {31'd0, rsp_error, rsp_rdata}, {32'd0, erd});
        else
            check(rsp_error == 1'b0, "R11 populated write ok", {63'd0, rsp_error}, 64'd0);
        check(rsp_rdata == erd, "R11 response data", {32'd0, rsp_rdata}, {32'd0, erd});
        @(negedge clk);
        check(rsp_valid == 1'b0 && req_ready == 1'b1, "R2 ready after response",
              {62'd0, rsp_valid, req_ready}, 64'd1);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=%0d expected=done", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] a;
        logic [2:0]  s;
        void'($urandom(32'd20240611));
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_size = 3'd4; req_wdata = '0; cfg_latency = 8'd0;
        base_addr = 32'h4000_0000;
        present_mask = '0;
        for (int i = 0; i < 8; i++) present_mask[i*32 +: 32] = $urandom;
        present_mask[{5'd3, 3'd1}] = 1'b1;
        present_mask[{5'd3, 3'd2}] = 1'b0;
        present_mask[{5'd31, 3'd7}] = 1'b1;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0 && rsp_error == 1'b0 && dn_valid == 1'b0,
              "R1 reset state", {60'd0, req_ready, rsp_valid, rsp_error, dn_valid}, 64'h8);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 after reset release",
              {62'd0, req_ready, rsp_valid}, 64'h2);

        // directed corners
        access(1'b0, base_addr + 32'h0000_1900 + 32'h10, 3'd4, 32'h0, 8'd0);   // R10 populated, lat 0
        access(1'b0, base_addr + 32'h0000_1900 + 32'h11, 3'd1, 32'h0, 8'd3);   // R10 byte
        access(1'b0, base_addr + 32'h0000_1A00, 3'd1, 32'h0, 8'd2);            // R7 byte
        access(1'b0, base_addr + 32'h0000_1A00, 3'd2, 32'h0, 8'd1);            // R7 half
        access(1'b0, base_addr + 32'h0000_1A00, 3'd4, 32'h0, 8'd0);            // R7 word
        access(1'b1, base_addr + 32'h0000_1A04, 3'd4, 32'hDEAD_BEEF, 8'd2);    // R8
        access(1'b1, base_addr + 32'h0000_1904, 3'd2, 32'h1234_5678, 8'd4);    // R11
        access(1'b0, base_addr + 32'h0000_1900, 3'd3, 32'h0, 8'd1);            // R6
        access(1'b0, base_addr + 32'h0000_1900, 3'd0, 32'h0, 8'd0);            // R6
        access(1'b0, base_addr + 32'h00FF_FFFE, 3'd1, 32'h0, 8'd1);            // R4 last in
        access(1'b0, base_addr + 32'h00FF_FFFF, 3'd1, 32'h0, 8'd1);            // R4 first out
        access(1'b0, base_addr - 32'h1, 3'd4, 32'h0, 8'd0);                    // R4 below base
        access(1'b0, base_addr + 32'h0000_1910, 3'd4, 32'h0, 8'd20);           // R3 long

        // random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(9) == 0)
                a = base_addr + 32'h00FF_0000 + $urandom_range(32'h1_FFFF);
            else if ($urandom_range(19) == 0)
                a = base_addr - $urandom_range(32'hFFFF) - 1;
            else
                a = base_addr + {8'd0, 24'($urandom_range(32'hFF_FFFE))};
            if ($urandom_range(5) == 0) s = 3'($urandom_range(7));
            else case ($urandom_range(2))
                0: s = 3'd1;
                1: s = 3'd2;
                default: s = 3'd4;
            endcase
            access(1'($urandom_range(1)), a, s, $urandom, 8'($urandom_range(7)));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule